// File: doc/BRIEF.md
# Pin-Level Input Capture Timer

This block is a memory-mapped capture peripheral built around a 16-bit up-counter. Software picks one of eight digital input pins and a level, starts the counter, and moves on to other work. The first time the chosen pin shows that level, the block stores the counter value in a read-only capture register, halts the counter and raises a done flag. The stored value is the elapsed time since the counter was last cleared.

The pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer before it is compared. A level that is applied before clock edge k therefore causes a capture at edge k+2. The captured value is the count held just before that edge.

After a capture the unit is disarmed. Later matches leave the captured value alone until software writes the control register with the clear bit set. That write zeroes the counter, drops the done flag and arms the unit again.

Top module: `pin_capture_timer`

## Requirements
- R1: After reset the capture register (offset 0x00), the control register (offset 0x02) and the status register (offset 0x04) all read 0.
- R2: While control bit 6 (run) is 1, the counter advances by one per clock and wraps from 0xFFFF to 0x0000. Writing bit 6 as 0 freezes the counter, and writing it as 1 again resumes counting from the frozen value.
- R3: A control write with bit 7 set zeroes the counter, clears the done flag and arms the unit. Bits 10:8 (pin select), bit 6 (run) and bit 0 (level) are taken from the same write. Bit 7 always reads back 0.
- R4: While the unit is armed and running, the synchronized selected pin is compared with bit 0. A level applied before edge k is captured at edge k+2, and the capture register then holds the count present just before edge k+2. A counter cleared and started at edge E and matched from edge K on therefore yields K-E+2, modulo 2^16. This holds for both level 1 and level 0.
- R5: A capture sets status bit 0, clears control bit 6 and halts the counter.
- R6: Once a capture has happened, further matches do not change the capture register, even if run is set again, until a control write with bit 7 set.
- R7: Any write to the status offset clears status bit 0 and leaves the capture register unchanged.
- R8: Writes to offset 0x00 have no effect on the capture register.
- R9: Pins other than the selected one have no effect on capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Candidate input pins, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte offset of the register access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |

## Verification
Every cycle, the assertions check the following:
- a capture stores the count present in that cycle;
- a capture halts the counter and drops run;
- a running counter advances by exactly one;
- a clear zeroes the counter and the done flag;
- a disarmed unit never fires again;
- writes to the capture offset and to the status offset affect only what they should.

Other behaviour only the bench scenarios can show:
- the two-cycle synchronizer latency, seen in the absolute captured values;
- that non-selected pins are ignored;
- freeze and resume of the counter;
- wrap past 0xFFFF;
- a capture that fires at once when the pin already matches at rearm.

// File: rtl/ic_pkg.sv
package ic_pkg;
  // control field positions, shared with software
  localparam int unsigned CTRL_LVL_BIT = 0;
  localparam int unsigned CTRL_RUN_BIT = 6;
  localparam int unsigned CTRL_CLR_BIT = 7;
  localparam int unsigned CTRL_SEL_LSB = 8;
  localparam int unsigned STAT_DONE_BIT = 0;
  // byte offsets
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTRL = 2;
  localparam int unsigned OFS_STAT = 4;
endpackage

// File: rtl/ic_pin_sync.sv
module ic_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ic_counter.sv
module ic_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r3_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/ic_capture.sv
module ic_capture #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_wr_i,
  input  logic                stat_wr_i,
  input  logic                clr_i,
  input  logic                run_wr_i,
  input  logic                lvl_wr_i,
  input  logic [SEL_W-1:0]    sel_wr_i,
  input  logic [NUM_PINS-1:0] pins_sync_i,
  input  logic [WIDTH-1:0]    cnt_i,
  output logic                run_o,
  output logic                lvl_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic                done_o,
  output logic                fire_o,
  output logic [WIDTH-1:0]    cap_o
);
  logic             run_q, lvl_q, done_q, armed_q;
  logic [SEL_W-1:0] sel_q;
  logic [WIDTH-1:0] cap_q;
  logic             match;

  assign match  = (pins_sync_i[sel_q] == lvl_q);
  // a control write in the same cycle wins; matching resumes next cycle
  assign fire_o = armed_q && run_q && match && !ctrl_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      lvl_q   <= 1'b0;
      sel_q   <= '0;
    end else if (ctrl_wr_i) begin
      run_q   <= run_wr_i;
      lvl_q   <= lvl_wr_i;
      sel_q   <= sel_wr_i;
    end else if (fire_o) begin
      run_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (fire_o) begin
      armed_q <= 1'b0;
      done_q  <= 1'b1;
    end else if (stat_wr_i) begin
      done_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (fire_o) cap_q <= cnt_i;
  end

  assign run_o  = run_q;
  assign lvl_o  = lvl_q;
  assign sel_o  = sel_q;
  assign done_o = done_q;
  assign cap_o  = cap_q;

  a_r6_single_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !clr_i) |=> !fire_o);
  a_r7_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !fire_o && !clr_i) |=> (!done_o && $stable(cap_o)));
endmodule

// File: rtl/pin_capture_timer.sv
module pin_capture_timer #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  import ic_pkg::*;

  localparam int unsigned SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic                ctrl_wr, stat_wr, data_wr, clr;
  logic [NUM_PINS-1:0] pins_sync;
  logic [DATA_W-1:0]   cnt, cap;
  logic                run, lvl, done, fire;
  logic [SEL_W-1:0]    sel;

  assign ctrl_wr = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign stat_wr = we_i && (addr_i == ADDR_W'(OFS_STAT));
  assign data_wr = we_i && (addr_i == ADDR_W'(OFS_DATA));
  assign clr     = ctrl_wr && wdata_i[CTRL_CLR_BIT];

  ic_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(pins_sync)
  );

  ic_counter #(.WIDTH(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(run && !fire), .cnt_o(cnt)
  );

  ic_capture #(.WIDTH(DATA_W), .NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_cap (
    .clk_i, .rst_ni,
    .ctrl_wr_i(ctrl_wr), .stat_wr_i(stat_wr), .clr_i(clr),
    .run_wr_i(wdata_i[CTRL_RUN_BIT]), .lvl_wr_i(wdata_i[CTRL_LVL_BIT]),
    .sel_wr_i(wdata_i[CTRL_SEL_LSB +: SEL_W]),
    .pins_sync_i(pins_sync), .cnt_i(cnt),
    .run_o(run), .lvl_o(lvl), .sel_o(sel), .done_o(done),
    .fire_o(fire), .cap_o(cap)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_DATA)) begin
      rdata_o = cap;
    end else if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata_o[CTRL_SEL_LSB +: SEL_W] = sel;
      rdata_o[CTRL_RUN_BIT]          = run;
      rdata_o[CTRL_LVL_BIT]          = lvl;
    end else if (addr_i == ADDR_W'(OFS_STAT)) begin
      rdata_o[STAT_DONE_BIT]         = done;
    end
  end

  a_r4_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (cap == $past(cnt)));
  a_r5_halt_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (cnt == $past(cnt) && !run && done));
  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !fire && !clr) |=> (cnt == DATA_W'($past(cnt) + 1'b1)));
  a_r3_clear_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !done);
  a_r8_data_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !fire) |=> $stable(cap));
endmodule

// File: tb/pin_capture_timer_tb.sv
module pin_capture_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pins_i = '0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  pin_capture_timer u_dut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // behavioural reference model
  int       m_cnt, m_cap, m_sel;
  bit       m_run, m_lvl, m_done, m_armed;
  bit [7:0] m_p1, m_p2;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_cap = 0; m_sel = 0; m_run = 0; m_lvl = 0;
      m_done = 0; m_armed = 1; m_p1 = 0; m_p2 = 0;
    end else begin
      bit cw, sw, hit;
      cw  = we_i && addr_i == 3'd2;
      sw  = we_i && addr_i == 3'd4;
      hit = m_armed && m_run && !cw && (m_p2[m_sel] == m_lvl);
      if (hit) begin
        m_cap = m_cnt; m_done = 1; m_armed = 0; m_run = 0;
      end else if (m_run) begin
        m_cnt = (m_cnt + 1) % 65536;
      end
      if (sw && !hit) m_done = 0;
      if (cw) begin
        m_run = wdata_i[6]; m_lvl = wdata_i[0]; m_sel = int'(wdata_i[10:8]);
        if (wdata_i[7]) begin m_cnt = 0; m_done = 0; m_armed = 1; end
      end
      m_p2 = m_p1; m_p1 = pins_i;
    end
  end

  function automatic int model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cap;
      3'd2: return (m_sel << 8) | (int'(m_run) << 6) | int'(m_lvl);
      3'd4: return int'(m_done);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (int'(rdata_o) != model_rd(addr_i)) begin
        errors++;
        $display("FAIL R4 model addr %0d: actual %h expected %h",
                 addr_i, rdata_o, model_rd(addr_i));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk_i); #1;
    addr_i = a;
    @(negedge clk_i);
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, rdata_o, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e, k, s, r;
    logic [15:0] first_cap;
    waitc(3);
    rst_ni = 1'b1;
    rd(3'd0, 16'h0, "R1 data");
    rd(3'd2, 16'h0, "R1 ctrl");
    rd(3'd4, 16'h0, "R1 status");

    // pin 3, level 1
    wr(3'd2, 16'h03C1); e = cyc;
    rd(3'd2, 16'h0341, "R3 ctrl readback");
    pins_i[5] = 1'b1;
    waitc(4);
    rd(3'd4, 16'h0, "R9 other pin ignored");
    k = cyc; pins_i[3] = 1'b1;
    first_cap = 16'(k - e + 2);
    waitc(5);
    rd(3'd0, first_cap, "R4 capture level 1");
    rd(3'd4, 16'h1, "R5 done set");
    rd(3'd2, 16'h0301, "R5 run cleared");

    // no recapture without clear
    pins_i[3] = 1'b0; waitc(3); pins_i[3] = 1'b1;
    wr(3'd2, 16'h0341);
    waitc(8);
    rd(3'd0, first_cap, "R6 no overwrite");

    wr(3'd4, 16'h0);
    rd(3'd4, 16'h0, "R7 status write clears");
    rd(3'd0, first_cap, "R7 capture kept");
    wr(3'd0, 16'h1234);
    rd(3'd0, first_cap, "R8 data write ignored");

    // rearm, pin 3 level 0
    wr(3'd2, 16'h03C0); e = cyc;
    rd(3'd4, 16'h0, "R3 clear drops done");
    k = cyc; pins_i[3] = 1'b0;
    waitc(5);
    rd(3'd0, 16'(k - e + 2), "R4 capture level 0");

    // immediate match on rearm
    pins_i = '0; waitc(3);
    wr(3'd2, 16'h00C0);
    waitc(4);
    rd(3'd0, 16'h0, "R4 immediate capture");

    // freeze and resume
    wr(3'd2, 16'h01C1); e = cyc;
    waitc(10);
    wr(3'd2, 16'h0101); s = cyc;
    waitc(20);
    wr(3'd2, 16'h0141); r = cyc;
    waitc(7);
    k = cyc; pins_i[1] = 1'b1;
    waitc(5);
    rd(3'd0, 16'((s - e) + (k + 2 - r)), "R2 freeze resume");

    // wrap past 0xFFFF
    pins_i[1] = 1'b0; waitc(3);
    wr(3'd2, 16'h02C1); e = cyc;
    waitc(65541);
    k = cyc; pins_i[2] = 1'b1;
    waitc(5);
    rd(3'd0, 16'(k - e + 2), "R2 wrap");
    rd(3'd4, 16'h1, "R5 done after wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule